// File: doc/BRIEF.md
# Memory-Map Decoder with Address-Triggered Control Latches

This block sits beside an 8-bit processor and turns the upper address bits into device selects and control events. Six active-low chip selects cover the program-store and RAM windows of a 64 KiB map. An active-high display enable covers one 64-byte window of the I/O area. The rest of the I/O area, 0x0100-0x03FF, is split into 64-byte granules. Touching a granule sets or clears a control latch, or fires a one-clock strobe toward an external divider chain.

The block has no data or read/write inputs. An event therefore depends only on which granule is addressed when an access begins. An access is marked by `acc_valid`, and its rising edge, sampled on `clk`, triggers at most one event, however long the access lasts. A strap input chooses whether the chip selects are qualified by the bus E clock or follow the address alone. A wake request from outside, such as a key press or a timer timeout, sets the power latch. A switch-off access clears it.

Top module: `memmap_decoder`

## Requirements
- R1: `addr_hi` carries address bits 15:6. `cs_n[0]` covers 0x8000-0xFFFF, `cs_n[1]` covers 0xE000-0xFFFF, `cs_n[2]` covers 0xC000-0xDFFF, `cs_n[3]` covers 0x4000-0x5FFF, `cs_n[4]` covers 0x2000-0x3FFF and `cs_n[5]` covers 0x0400-0x7FFF. Each select is low while its window is addressed and high otherwise. It is combinational in the address.
- R2: With `gate_strap`=1, a select goes low only while `e_clk` is high. With `gate_strap`=0, `e_clk` has no effect on the selects.
- R3: `lcd_en` is high exactly while the address lies in 0x0180-0x01BF, independent of `e_clk` and `acc_valid`.
- R4: An event occurs only on a clock edge where `acc_valid` is 1 and was 0 at the previous edge. Holding `acc_valid` high does not repeat the event. A latch changed by an event shows its new value from that edge onward.
- R5: An access to 0x0280-0x02BF sets `alarm` and an access to 0x02C0-0x02FF clears it. A second set access leaves `alarm` at 1.
- R6: An access to 0x0380-0x03BF sets `nmi_en`. An access to 0x03C0-0x03FF, or a switch-off access, clears it.
- R7: An access to 0x0200-0x023F sets `pulse_en` and an access to 0x0240-0x027F clears it. `pulse_en` is 0 in every cycle where `sys_on` is 0, and a set access is ignored while `sys_on` is 0.
- R8: `wake_req` high at a clock edge sets `sys_on`. An access to 0x01C0-0x01FF clears it. If both arrive at the same edge, the clear wins.
- R9: An access to 0x0300-0x033F makes `cnt_rst_pulse` high, and an access to 0x0340-0x037F makes `cnt_clk_pulse` high. Each pulse lasts for exactly the one cycle after the triggering edge.
- R10: Accesses to 0x0100-0x017F, to the display window, or to any address outside 0x0100-0x03FF change no latch and fire no strobe.
- R11: While `rst_n` is low, all latches and strobes are 0, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| addr_hi | input | 10 | Address bits 15:6 |
| e_clk | input | 1 | Bus E clock, used to qualify selects in gated mode |
| acc_valid | input | 1 | Access in progress; its rising edge triggers events |
| gate_strap | input | 1 | 1: selects gated by `e_clk`; 0: address only |
| wake_req | input | 1 | External switch-on request |
| cs_n | output | 6 | Active-low memory chip selects |
| lcd_en | output | 1 | Display window select, active high |
| sys_on | output | 1 | Power (on/off) latch |
| pulse_en | output | 1 | Pulse-generator enable latch |
| alarm | output | 1 | Buzzer latch, driven directly |
| nmi_en | output | 1 | One-second interrupt enable latch |
| cnt_rst_pulse | output | 1 | One-cycle divider reset strobe |
| cnt_clk_pulse | output | 1 | One-cycle divider clock strobe |

## Verification
Properties checked on every cycle:
- Selects stay inactive while gated mode holds E low.
- The display window never overlaps a memory select.
- `pulse_en` is never 1 while `sys_on` is 0.
- Neither strobe lasts two cycles.
- The alarm and interrupt latches stay still after any cycle without an access.

Only the bench scenarios can show the following:
- The exact window boundaries.
- The set and clear behaviour of each latch across sequences.
- The switch-off side effects on the other latches.
- The priority of switch-off over a simultaneous wake.
- That one long access yields a single strobe.

// File: rtl/memdec_pkg.sv
`timescale 1ns/1ps
package memdec_pkg;

   localparam int MAP_W  = 16;
   localparam int CS_CNT = 6;

   // granule codes within the I/O area (address bits 9:6)
   typedef enum logic [3:0] {
      GR_LCD       = 4'd6,
      GR_OFF       = 4'd7,
      GR_PULSE_ON  = 4'd8,
      GR_PULSE_OFF = 4'd9,
      GR_ALARM_SET = 4'd10,
      GR_ALARM_CLR = 4'd11,
      GR_CNT_RST   = 4'd12,
      GR_CNT_CLK   = 4'd13,
      GR_NMI_ON    = 4'd14,
      GR_NMI_OFF   = 4'd15
   } io_gran_e;

   typedef struct packed {
      logic lcd;
      logic off;
      logic pulse_on;
      logic pulse_off;
      logic alarm_set;
      logic alarm_clr;
      logic cnt_rst;
      logic cnt_clk;
      logic nmi_on;
      logic nmi_off;
   } io_hit_t;

   function automatic logic [MAP_W-1:0] cs_first(input int k);
      case (k)
         0:       cs_first = 16'h8000;
         1:       cs_first = 16'hE000;
         2:       cs_first = 16'hC000;
         3:       cs_first = 16'h4000;
         4:       cs_first = 16'h2000;
         default: cs_first = 16'h0400;
      endcase
   endfunction

   function automatic logic [MAP_W-1:0] cs_last(input int k);
      case (k)
         0:       cs_last = 16'hFFFF;
         1:       cs_last = 16'hFFFF;
         2:       cs_last = 16'hDFFF;
         3:       cs_last = 16'h5FFF;
         4:       cs_last = 16'h3FFF;
         default: cs_last = 16'h7FFF;
      endcase
   endfunction

endpackage

// File: rtl/memdec_cs_decode.sv
`timescale 1ns/1ps
module memdec_cs_decode #(
   parameter int ADDR_W = 16,
   parameter int GRAN_W = 6,
   parameter int NUM_CS = 6,
   localparam int HI_W  = ADDR_W - GRAN_W
) (
   input  logic [HI_W-1:0]   addr_hi,
   input  logic              e_clk,
   input  logic              gate_strap,
   output logic [NUM_CS-1:0] cs_n
);
   import memdec_pkg::*;

   if (ADDR_W != MAP_W) begin : g_bad_addr
      $error("memdec_cs_decode: ADDR_W must equal the map width");
   end
   if (NUM_CS != CS_CNT) begin : g_bad_cnt
      $error("memdec_cs_decode: NUM_CS must equal the window count");
   end

   logic qual;
   assign qual = gate_strap ? e_clk : 1'b1;

   for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
      localparam logic [ADDR_W-1:0] FIRST = cs_first(k);
      localparam logic [ADDR_W-1:0] LAST  = cs_last(k);
      localparam logic [HI_W-1:0]   BASE  = FIRST[ADDR_W-1:GRAN_W];
      localparam logic [HI_W-1:0]   SPAN  = LAST[ADDR_W-1:GRAN_W] - FIRST[ADDR_W-1:GRAN_W];
      logic [HI_W-1:0] off;
      logic            hit;
      assign off     = addr_hi - BASE;
      assign hit     = (off <= SPAN);
      assign cs_n[k] = ~(hit & qual);
   end

endmodule

// File: rtl/memdec_io_decode.sv
`timescale 1ns/1ps
module memdec_io_decode #(
   parameter int ADDR_W = 16,
   parameter int GRAN_W = 6,
   parameter int IO_TOP = 'h0400,
   localparam int HI_W  = ADDR_W - GRAN_W,
   localparam int SEL_W = $clog2(IO_TOP >> GRAN_W)
) (
   input  logic [HI_W-1:0]     addr_hi,
   output memdec_pkg::io_hit_t hit
);
   import memdec_pkg::*;

   if (GRAN_W != 6 || IO_TOP != 'h0400) begin : g_bad_gran
      $error("memdec_io_decode: granule map assumes 64-byte granules below 0x400");
   end

   logic             in_io;
   logic [SEL_W-1:0] sel;

   assign in_io = (addr_hi[HI_W-1:SEL_W] == '0);
   assign sel   = addr_hi[SEL_W-1:0];

   always_comb begin
      hit = '0;
      if (in_io) begin
         case (sel)
            GR_LCD:       hit.lcd       = 1'b1;
            GR_OFF:       hit.off       = 1'b1;
            GR_PULSE_ON:  hit.pulse_on  = 1'b1;
            GR_PULSE_OFF: hit.pulse_off = 1'b1;
            GR_ALARM_SET: hit.alarm_set = 1'b1;
            GR_ALARM_CLR: hit.alarm_clr = 1'b1;
            GR_CNT_RST:   hit.cnt_rst   = 1'b1;
            GR_CNT_CLK:   hit.cnt_clk   = 1'b1;
            GR_NMI_ON:    hit.nmi_on    = 1'b1;
            GR_NMI_OFF:   hit.nmi_off   = 1'b1;
            default:      hit           = '0;
         endcase
      end
   end

endmodule

// File: rtl/memdec_setclr.sv
`timescale 1ns/1ps
module memdec_setclr #(
   parameter bit CLR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   if (CLR_WINS) begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= 1'b0;
         else if (clr) q <= 1'b0;
         else if (set) q <= 1'b1;
      end
   end else begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= 1'b0;
         else if (set) q <= 1'b1;
         else if (clr) q <= 1'b0;
      end
   end
endmodule

// File: rtl/memmap_decoder.sv
`timescale 1ns/1ps
module memmap_decoder #(
   parameter int ADDR_W = 16,
   parameter int GRAN_W = 6,
   parameter int NUM_CS = 6,
   localparam int HI_W  = ADDR_W - GRAN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HI_W-1:0]   addr_hi,
   input  logic              e_clk,
   input  logic              acc_valid,
   input  logic              gate_strap,
   input  logic              wake_req,
   output logic [NUM_CS-1:0] cs_n,
   output logic              lcd_en,
   output logic              sys_on,
   output logic              pulse_en,
   output logic              alarm,
   output logic              nmi_en,
   output logic              cnt_rst_pulse,
   output logic              cnt_clk_pulse
);
   import memdec_pkg::*;

   if (GRAN_W >= ADDR_W) begin : g_bad_widths
      $error("memmap_decoder: GRAN_W must be below ADDR_W");
   end

   memdec_cs_decode #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .NUM_CS(NUM_CS)) u_cs (
      .addr_hi(addr_hi), .e_clk(e_clk), .gate_strap(gate_strap), .cs_n(cs_n)
   );

   io_hit_t hit;
   memdec_io_decode #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_io (
      .addr_hi(addr_hi), .hit(hit)
   );

   assign lcd_en = hit.lcd;

   // access start detection
   logic acc_q;
   logic start;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= 1'b0;
      else        acc_q <= acc_valid;
   end
   assign start = acc_valid & ~acc_q;

   io_hit_t ev;
   assign ev = start ? hit : '0;

   memdec_setclr #(.CLR_WINS(1'b1)) u_on (
      .clk(clk), .rst_n(rst_n), .set(wake_req), .clr(ev.off), .q(sys_on)
   );
   memdec_setclr #(.CLR_WINS(1'b1)) u_pulse (
      .clk(clk), .rst_n(rst_n), .set(ev.pulse_on),
      .clr(ev.pulse_off | ev.off | ~sys_on), .q(pulse_en)
   );
   memdec_setclr #(.CLR_WINS(1'b1)) u_alarm (
      .clk(clk), .rst_n(rst_n), .set(ev.alarm_set), .clr(ev.alarm_clr), .q(alarm)
   );
   memdec_setclr #(.CLR_WINS(1'b1)) u_nmi (
      .clk(clk), .rst_n(rst_n), .set(ev.nmi_on), .clr(ev.nmi_off | ev.off), .q(nmi_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_rst_pulse <= 1'b0;
         cnt_clk_pulse <= 1'b0;
      end else begin
         cnt_rst_pulse <= ev.cnt_rst;
         cnt_clk_pulse <= ev.cnt_clk;
      end
   end

   AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_strap && !e_clk) |-> (&cs_n));                               // R2
   AST_LCD_NOT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |-> (&cs_n));                                                // R3
   AST_ALARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(alarm));                                     // R4
   AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(nmi_en));                                    // R4
   AST_PULSE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_on |-> !pulse_en);                                             // R7
   AST_CLK_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clk_pulse |=> !cnt_clk_pulse);                                  // R9
   AST_RST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_pulse |=> !cnt_rst_pulse);                                  // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_rst_pulse && cnt_clk_pulse));                                 // R9

endmodule

// File: tb/memmap_decoder_test.sv
`timescale 1ns/1ps
module memmap_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] addr_hi = '0;
   logic       e_clk = 1'b0, acc_valid = 1'b0, gate_strap = 1'b0, wake_req = 1'b0;
   logic [5:0] cs_n;
   logic       lcd_en, sys_on, pulse_en, alarm, nmi_en, cnt_rst_pulse, cnt_clk_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] cur_addr = '0;

   always #2.5 clk = ~clk;

   memmap_decoder uut (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .e_clk(e_clk),
      .acc_valid(acc_valid), .gate_strap(gate_strap), .wake_req(wake_req),
      .cs_n(cs_n), .lcd_en(lcd_en), .sys_on(sys_on), .pulse_en(pulse_en),
      .alarm(alarm), .nmi_en(nmi_en), .cnt_rst_pulse(cnt_rst_pulse),
      .cnt_clk_pulse(cnt_clk_pulse)
   );

   // behavioural reference state
   bit m_prev, m_on, m_pulse, m_alarm, m_nmi, m_crst, m_cclk;

   function automatic bit in_win(logic [15:0] a, int lo, int hi);
      return (int'(a) >= lo) && (int'(a) <= hi);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev = 0; m_on = 0; m_pulse = 0; m_alarm = 0; m_nmi = 0; m_crst = 0; m_cclk = 0;
      end else begin
         bit st, off, old_on;
         st = acc_valid && !m_prev;
         m_prev = acc_valid;
         old_on = m_on;
         off = st && in_win(cur_addr, 'h01C0, 'h01FF);
         m_crst = st && in_win(cur_addr, 'h0300, 'h033F);
         m_cclk = st && in_win(cur_addr, 'h0340, 'h037F);
         if (off) m_on = 0; else if (wake_req) m_on = 1;
         if (!old_on || off || (st && in_win(cur_addr, 'h0240, 'h027F))) m_pulse = 0;
         else if (st && in_win(cur_addr, 'h0200, 'h023F)) m_pulse = 1;
         if (st && in_win(cur_addr, 'h02C0, 'h02FF)) m_alarm = 0;
         else if (st && in_win(cur_addr, 'h0280, 'h02BF)) m_alarm = 1;
         if (off || (st && in_win(cur_addr, 'h03C0, 'h03FF))) m_nmi = 0;
         else if (st && in_win(cur_addr, 'h0380, 'h03BF)) m_nmi = 1;
      end
   end

   function automatic logic [5:0] exp_cs(logic [15:0] a, bit e, bit strap);
      logic [5:0] r;
      bit q = strap ? e : 1'b1;
      r[0] = !(q && in_win(a, 'h8000, 'hFFFF));
      r[1] = !(q && in_win(a, 'hE000, 'hFFFF));
      r[2] = !(q && in_win(a, 'hC000, 'hDFFF));
      r[3] = !(q && in_win(a, 'h4000, 'h5FFF));
      r[4] = !(q && in_win(a, 'h2000, 'h3FFF));
      r[5] = !(q && in_win(a, 'h0400, 'h7FFF));
      return r;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h addr=%h t=%0t", tag, act, exp, cur_addr, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 R2 cs_n", {2'b0, cs_n}, {2'b0, exp_cs(cur_addr, e_clk, gate_strap)});
      chk("R3 lcd_en", {7'b0, lcd_en}, {7'b0, in_win(cur_addr, 'h0180, 'h01BF)});
      chk("R8 sys_on", {7'b0, sys_on}, {7'b0, m_on});
      chk("R7 pulse_en", {7'b0, pulse_en}, {7'b0, m_pulse});
      chk("R5 alarm", {7'b0, alarm}, {7'b0, m_alarm});
      chk("R6 nmi_en", {7'b0, nmi_en}, {7'b0, m_nmi});
      chk("R9 R4 cnt_rst_pulse", {7'b0, cnt_rst_pulse}, {7'b0, m_crst});
      chk("R9 R4 cnt_clk_pulse", {7'b0, cnt_clk_pulse}, {7'b0, m_cclk});
   endtask

   task automatic cyc(logic [15:0] a, bit acc, bit e, bit strap, bit wake);
      @(negedge clk);
      cur_addr = a; addr_hi = a[15:6]; acc_valid = acc; e_clk = e;
      gate_strap = strap; wake_req = wake;
      #1 compare_all();
   endtask

   task automatic access(logic [15:0] a, int len);
      for (int i = 0; i < len; i++) cyc(a, 1, 1, 0, 0);
      cyc(a, 0, 0, 0, 0);
      cyc(16'h0000, 0, 0, 0, 0);
   endtask

   localparam logic [15:0] EDGES [16] = '{16'h03FF, 16'h0400, 16'h1FFF, 16'h2000,
      16'h3FFF, 16'h4000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hBFFF,
      16'hC000, 16'hDFFF, 16'hE000, 16'hFFFF, 16'h0000};

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] snap;
      // R11: reset state
      for (int i = 0; i < 3; i++) cyc(16'h0280, 1, 1, 0, 1);
      chk("R11 latches in reset", {4'b0, sys_on, pulse_en, alarm, nmi_en}, 8'h00);
      cyc(16'h0000, 0, 0, 0, 0);
      rst_n = 1'b1;
      // R1 R2: window boundaries in both strap modes and both E levels
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 2; e++)
            for (int k = 0; k < 16; k++) cyc(EDGES[k], 0, e[0], s[0], 0);
      // R3: every I/O granule
      for (int g = 4; g < 16; g++) cyc(16'(g * 64 + 5), 0, 1, 0, 0);
      cyc(16'h01BF, 0, 1, 0, 0);
      cyc(16'h01C0, 0, 1, 0, 0);
      // R5: set, repeated set, clear
      access(16'h0280, 1);
      access(16'h02A5, 1);
      chk("R5 repeated set keeps alarm", {7'b0, alarm}, 8'h01);
      access(16'h02C0, 1);
      // R4 R9: long access gives one strobe
      access(16'h0300, 5);
      access(16'h0340, 4);
      access(16'h0345, 1);
      // R7: pulse set ignored while off
      access(16'h0200, 1);
      chk("R7 pulse set while off", {7'b0, pulse_en}, 8'h00);
      cyc(16'h0000, 0, 0, 0, 1);
      cyc(16'h0000, 0, 0, 0, 0);
      access(16'h0200, 1);
      chk("R7 pulse set while on", {7'b0, pulse_en}, 8'h01);
      access(16'h0240, 1);
      access(16'h0200, 1);
      // R6: enable, then switch-off clears nmi, pulse and on
      access(16'h0380, 1);
      access(16'h0280, 1);
      access(16'h01C0, 2);
      chk("R8 R6 R7 switch-off", {5'b0, sys_on, pulse_en, nmi_en}, 8'h00);
      chk("R5 alarm survives switch-off", {7'b0, alarm}, 8'h01);
      access(16'h0380, 1);
      access(16'h03C0, 1);
      // R8: wake and switch-off together
      cyc(16'h0000, 0, 0, 0, 1);
      cyc(16'h01C0, 1, 1, 0, 1);
      cyc(16'h01C0, 0, 1, 0, 0);
      chk("R8 off wins over wake", {7'b0, sys_on}, 8'h00);
      // R10: unused and non-latch addresses
      cyc(16'h0000, 0, 0, 0, 1);
      access(16'h0380, 1);
      snap = {sys_on, pulse_en, alarm, nmi_en};
      access(16'h0100, 1);
      access(16'h0140, 1);
      access(16'h0180, 1);
      access(16'h0040, 1);
      access(16'h0400, 1);
      access(16'h8300, 1);
      chk("R10 no change from inert accesses", {4'b0, sys_on, pulse_en, alarm, nmi_en}, {4'b0, snap});
      // R11: reset mid-run
      @(negedge clk); rst_n = 1'b0; #1;
      chk("R11 async clear", {4'b0, sys_on, pulse_en, alarm, nmi_en}, 8'h00);
      cyc(16'h0000, 0, 0, 0, 0);
      rst_n = 1'b1;
      cyc(16'h0300, 1, 1, 1, 0);
      cyc(16'h0300, 0, 0, 1, 0);
      cyc(16'h0000, 0, 0, 0, 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule